// File: doc/BRIEF.md
# Five-Bit Serial Command Receiver

This block accepts command words from a host microcontroller over a three-wire serial link made of data, clock and enable, plus a fourth line that selects serial operation. All four lines are asynchronous to the block's clock. Each one passes through a synchroniser, and the clock and enable edges are detected in the block's clock domain. On every rising edge of the serial clock one data bit moves into a five-bit shift register, with the most significant bit of the word sent first. A rising edge of the enable line takes the last five bits as one command. The host is expected to leave at least 900 µs between two commands.

A command can produce one of three kinds of result. It can be a dial-key strobe carrying a key value. It can be a one-cycle pulse that asks for a flash, a redial, a pause or a confidence tone. It can change a held setting: the loudspeaker-on toggle, the microphone-mute toggle or a three-bit loudspeaker gain. The dialler reports when it is busy. The block sends this back to the host as a free line and drops any key commands that arrive while the dialler is busy.

A small controller sequences the work in three states. S_OFF is entered from reset and from any state while serial mode is deselected. In S_OFF the shift register is held clear. S_OFF goes to S_LISTEN when serial mode is selected. S_LISTEN goes to S_EXEC on an enable rising edge, and at that point it latches the shifted word. S_LISTEN goes back to S_OFF if serial mode is dropped. S_EXEC lasts exactly one cycle: it applies the decoded command to the registered outputs, then returns to S_LISTEN, or to S_OFF if serial mode has been dropped.

Top module: `serial_cmd_rx`

## Requirements
- R1: While the serial-mode line is low, serial clock and enable activity produces no pulse and changes no held setting. Bits shifted before serial mode is selected again are discarded, so the register restarts from all zeros.
- R2: Bits are shifted most significant bit first on rising serial-clock edges. A rising enable edge takes the last five bits shifted. Extra leading bits fall out of the register.
- R3: Codes 00001 to 01001 strobe key values 1 to 9, and 01010 strobes key value 0. Codes 01011 to 01110 strobe values 10 to 13 (keys A to D). Codes 00000 and 01111 strobe value 14 (star). The strobe lasts one cycle and the value is valid with it.
- R4: A key command whose execution cycle sees the dialler busy is dropped and gives no strobe.
- R5: Code 10001 pulses flash, 10010 pulses redial, 10110 pulses pause and 10100 pulses confidence tone. Each pulse lasts one cycle and is issued whether or not the dialler is busy.
- R6: Code 10011 inverts the loudspeaker-on level and code 10101 inverts the microphone-mute level, whether or not the dialler is busy.
- R7: Codes 11000 to 11111 set the loudspeaker gain output to the code's low three bits (step n means 3n dB), whether or not the dialler is busy.
- R8: Codes 10000 and 10111 produce no pulse and change no held setting.
- R9: The free line equals the inverse of the dialler-busy input, delayed by one clock.
- R10: During reset all pulses, both toggles, the gain and the free line are low.
- R11: A command produces at most one pulse, and no pulse output is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_mode_i | input | 1 | Serial operation select, high selects (asynchronous) |
| ser_clk_i | input | 1 | Serial clock from host (asynchronous) |
| ser_dat_i | input | 1 | Serial data from host (asynchronous) |
| ser_en_i | input | 1 | Enable from host, rising edge takes the word (asynchronous) |
| dial_busy_i | input | 1 | Dialler busy indication |
| digit_stb_o | output | 1 | One-cycle key strobe |
| digit_val_o | output | 4 | Key value: 0-9, 10-13 for A-D, 14 for star |
| flash_o | output | 1 | One-cycle flash request |
| redial_o | output | 1 | One-cycle redial request |
| pause_o | output | 1 | One-cycle pause request |
| tone_o | output | 1 | One-cycle confidence-tone request |
| spk_on_o | output | 1 | Loudspeaker-on toggle level |
| mic_mute_o | output | 1 | Microphone-mute toggle level |
| spk_gain_o | output | 3 | Loudspeaker gain step, 3 dB per step |
| host_free_o | output | 1 | Dialler free, returned to host |

## Verification
The bench sends two codes that are bit-reversals of each other, 00001 and 10000. A receiver that shifted least significant bit first would swap a key strobe for a reserved no-op. It sends a six-bit burst and a three-bit burst just after serial mode is re-selected. A design that kept stale bits, or counted bits instead of waiting for enable, would strobe the wrong key. It sends a full word while serial mode is low, which would wrongly change the gain on a design that shifts while deselected. The table also mixes busy and free cycles across key, function, toggle and gain codes. A design that gated everything on busy, or nothing at all, would lose a flash or let a key through.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int CMD_W   = 5;
    localparam int KEY_W   = 4;
    localparam int GAIN_W  = 3;
    localparam int STAR_V  = 14;

    typedef enum logic [1:0] {
        S_OFF,
        S_LISTEN,
        S_EXEC
    } rx_state_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_DIGIT,
        K_FLASH,
        K_REDIAL,
        K_SPK,
        K_TONE,
        K_MUTE,
        K_PAUSE,
        K_GAIN
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e        kind;
        logic [KEY_W-1:0] arg;
    } cmd_dec_t;

    // Upper half, upper quarter: gain field. Upper half, lower quarter: functions.
    // Lower half: key codes.
    function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] w);
        cmd_dec_t d;
        d.kind = K_NONE;
        d.arg  = '0;
        if (!w[CMD_W-1]) begin
            d.kind = K_DIGIT;
            if (w == 5'd0 || w == 5'd15)
                d.arg = KEY_W'(STAR_V);
            else if (w == 5'd10)
                d.arg = '0;
            else if (w < 5'd10)
                d.arg = w[KEY_W-1:0];
            else
                d.arg = w[KEY_W-1:0] - 4'd1;
        end else if (w[CMD_W-2]) begin
            d.kind = K_GAIN;
            d.arg  = {1'b0, w[GAIN_W-1:0]};
        end else begin
            case (w[2:0])
                3'b001:  d.kind = K_FLASH;
                3'b010:  d.kind = K_REDIAL;
                3'b011:  d.kind = K_SPK;
                3'b100:  d.kind = K_TONE;
                3'b101:  d.kind = K_MUTE;
                3'b110:  d.kind = K_PAUSE;
                default: d.kind = K_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (!rst_n)
                chain <= '0;
            else
                chain <= (chain << 1) | STAGES'(async_i[b]);
        end

        assign sync_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/scr_edge.sv
module scr_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else
            last_q <= level_i;
    end

    assign rise_o = level_i & ~last_q;

endmodule

// File: rtl/scr_shifter.sv
module scr_shifter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);

    logic [W-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg_q <= '0;
        else if (clear_i)
            shreg_q <= '0;
        else if (shift_i)
            shreg_q <= {shreg_q[W-2:0], bit_i};
    end

    assign word_o = shreg_q;

endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              en_rise_i,
    input  logic [CMD_W-1:0]  word_i,
    input  logic              dial_busy_i,
    output logic              rx_off_o,
    output logic              digit_stb_o,
    output logic [KEY_W-1:0]  digit_val_o,
    output logic              flash_o,
    output logic              redial_o,
    output logic              pause_o,
    output logic              tone_o,
    output logic              spk_on_o,
    output logic              mic_mute_o,
    output logic [GAIN_W-1:0] spk_gain_o,
    output logic              host_free_o
);

    rx_state_e        state_q, state_d;
    logic [CMD_W-1:0] cmd_q;
    cmd_dec_t         dec;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_OFF;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:    if (mode_i) state_d = S_LISTEN;
            S_LISTEN: begin
                if (!mode_i)        state_d = S_OFF;
                else if (en_rise_i) state_d = S_EXEC;
            end
            S_EXEC:   state_d = mode_i ? S_LISTEN : S_OFF;
            default:  state_d = S_OFF;
        endcase
    end

    // Command latch on the validating edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (state_q == S_LISTEN && mode_i && en_rise_i)
            cmd_q <= word_i;
    end

    assign dec      = decode_cmd(cmd_q);
    assign rx_off_o = (state_q == S_OFF);

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_stb_o <= 1'b0;
            digit_val_o <= '0;
            flash_o     <= 1'b0;
            redial_o    <= 1'b0;
            pause_o     <= 1'b0;
            tone_o      <= 1'b0;
            spk_on_o    <= 1'b0;
            mic_mute_o  <= 1'b0;
            spk_gain_o  <= '0;
            host_free_o <= 1'b0;
        end else begin
            digit_stb_o <= 1'b0;
            flash_o     <= 1'b0;
            redial_o    <= 1'b0;
            pause_o     <= 1'b0;
            tone_o      <= 1'b0;
            host_free_o <= ~dial_busy_i;
            if (state_q == S_EXEC) begin
                unique case (dec.kind)
                    K_DIGIT: begin
                        if (!dial_busy_i) begin
                            digit_stb_o <= 1'b1;
                            digit_val_o <= dec.arg;
                        end
                    end
                    K_FLASH:  flash_o    <= 1'b1;
                    K_REDIAL: redial_o   <= 1'b1;
                    K_PAUSE:  pause_o    <= 1'b1;
                    K_TONE:   tone_o     <= 1'b1;
                    K_SPK:    spk_on_o   <= ~spk_on_o;
                    K_MUTE:   mic_mute_o <= ~mic_mute_o;
                    K_GAIN:   spk_gain_o <= dec.arg[GAIN_W-1:0];
                    K_NONE:   ;
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import scr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode_i,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_en_i,
    input  logic              dial_busy_i,
    output logic              digit_stb_o,
    output logic [KEY_W-1:0]  digit_val_o,
    output logic              flash_o,
    output logic              redial_o,
    output logic              pause_o,
    output logic              tone_o,
    output logic              spk_on_o,
    output logic              mic_mute_o,
    output logic [GAIN_W-1:0] spk_gain_o,
    output logic              host_free_o
);

    localparam int N_IN   = 4;
    localparam int IX_MODE = 0;
    localparam int IX_SCLK = 1;
    localparam int IX_SEN  = 2;
    localparam int IX_SDAT = 3;

    logic [N_IN-1:0]  raw, synced;
    logic [1:0]       rises;
    logic [CMD_W-1:0] word;
    logic             rx_off;
    logic             shift_go;

    assign raw = {ser_dat_i, ser_en_i, ser_clk_i, ser_mode_i};

    scr_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    scr_edge #(.WIDTH(2)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({synced[IX_SEN], synced[IX_SCLK]}),
        .rise_o  (rises)
    );

    assign shift_go = rises[0] & synced[IX_MODE] & ~rx_off;

    scr_shifter #(.W(CMD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (rx_off),
        .shift_i (shift_go),
        .bit_i   (synced[IX_SDAT]),
        .word_o  (word)
    );

    scr_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (synced[IX_MODE]),
        .en_rise_i   (rises[1]),
        .word_i      (word),
        .dial_busy_i (dial_busy_i),
        .rx_off_o    (rx_off),
        .digit_stb_o (digit_stb_o),
        .digit_val_o (digit_val_o),
        .flash_o     (flash_o),
        .redial_o    (redial_o),
        .pause_o     (pause_o),
        .tone_o      (tone_o),
        .spk_on_o    (spk_on_o),
        .mic_mute_o  (mic_mute_o),
        .spk_gain_o  (spk_gain_o),
        .host_free_o (host_free_o)
    );

endmodule

// File: rtl/scr_chk.sv
module scr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_off,
    input logic       dial_busy_i,
    input logic       digit_stb_o,
    input logic [3:0] digit_val_o,
    input logic       flash_o,
    input logic       redial_o,
    input logic       pause_o,
    input logic       tone_o,
    input logic       spk_on_o,
    input logic       mic_mute_o,
    input logic [2:0] spk_gain_o,
    input logic       host_free_o
);

    logic [4:0] pulses;
    assign pulses = {digit_stb_o, flash_o, redial_o, pause_o, tone_o};

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        rx_off |=> (pulses == 5'b0) && $stable(spk_gain_o)
                   && $stable(spk_on_o) && $stable(mic_mute_o));

    a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses != 5'b0) |=> (pulses == 5'b0));

    a_r4_busy_drops_key: assert property (@(posedge clk) disable iff (!rst_n)
        digit_stb_o |-> !$past(dial_busy_i));

    a_r3_key_range: assert property (@(posedge clk) disable iff (!rst_n)
        digit_stb_o |-> (digit_val_o <= 4'd14));

    a_r9_free_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dial_busy_i) |=> !host_free_o);

endmodule

bind serial_cmd_rx scr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_off      (rx_off),
    .dial_busy_i (dial_busy_i),
    .digit_stb_o (digit_stb_o),
    .digit_val_o (digit_val_o),
    .flash_o     (flash_o),
    .redial_o    (redial_o),
    .pause_o     (pause_o),
    .tone_o      (tone_o),
    .spk_on_o    (spk_on_o),
    .mic_mute_o  (mic_mute_o),
    .spk_gain_o  (spk_gain_o),
    .host_free_o (host_free_o)
);

// File: tb/tb_serial_cmd_rx.sv
module tb_serial_cmd_rx;

    localparam int CLK_PERIOD = 10;

    localparam int E_NONE = 0, E_DIG = 1, E_FLASH = 2, E_REDIAL = 3, E_PAUSE = 4,
                   E_TONE = 5, E_SPK = 6, E_MUTE = 7, E_GAIN = 8;

    // {code[4:0], busy, effect[3:0], value[5:0]}
    localparam int NVEC = 23;
    localparam logic [15:0] VEC [NVEC] = '{
        {5'b00001, 1'b0, 4'd1, 6'd1},
        {5'b00101, 1'b0, 4'd1, 6'd5},
        {5'b01001, 1'b0, 4'd1, 6'd9},
        {5'b01010, 1'b0, 4'd1, 6'd0},
        {5'b01011, 1'b0, 4'd1, 6'd10},
        {5'b01110, 1'b0, 4'd1, 6'd13},
        {5'b01111, 1'b0, 4'd1, 6'd14},
        {5'b00000, 1'b0, 4'd1, 6'd14},
        {5'b00011, 1'b1, 4'd0, 6'd0},
        {5'b10001, 1'b0, 4'd2, 6'd0},
        {5'b10001, 1'b1, 4'd2, 6'd0},
        {5'b10010, 1'b0, 4'd3, 6'd0},
        {5'b10110, 1'b0, 4'd4, 6'd0},
        {5'b10100, 1'b1, 4'd5, 6'd0},
        {5'b10011, 1'b0, 4'd6, 6'd0},
        {5'b10011, 1'b1, 4'd6, 6'd0},
        {5'b10101, 1'b1, 4'd7, 6'd0},
        {5'b10000, 1'b0, 4'd0, 6'd0},
        {5'b10111, 1'b0, 4'd0, 6'd0},
        {5'b11000, 1'b0, 4'd8, 6'd0},
        {5'b11101, 1'b1, 4'd8, 6'd5},
        {5'b11111, 1'b0, 4'd8, 6'd7},
        {5'b11010, 1'b0, 4'd8, 6'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_mode = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0, busy = 1'b0;
    logic       digit_stb_o, flash_o, redial_o, pause_o, tone_o;
    logic       spk_on_o, mic_mute_o, host_free_o;
    logic [3:0] digit_val_o;
    logic [2:0] spk_gain_o;

    int checks = 0, errors = 0;
    int n_dig = 0, n_fl = 0, n_rd = 0, n_pa = 0, n_to = 0;
    logic [3:0] last_dig = '0;
    logic exp_spk = 1'b0, exp_mute = 1'b0;
    logic [2:0] exp_gain = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cmd_rx dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_mode_i  (ser_mode),
        .ser_clk_i   (ser_clk),
        .ser_dat_i   (ser_dat),
        .ser_en_i    (ser_en),
        .dial_busy_i (busy),
        .digit_stb_o (digit_stb_o),
        .digit_val_o (digit_val_o),
        .flash_o     (flash_o),
        .redial_o    (redial_o),
        .pause_o     (pause_o),
        .tone_o      (tone_o),
        .spk_on_o    (spk_on_o),
        .mic_mute_o  (mic_mute_o),
        .spk_gain_o  (spk_gain_o),
        .host_free_o (host_free_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (digit_stb_o) begin n_dig++; last_dig = digit_val_o; end
            if (flash_o)  n_fl++;
            if (redial_o) n_rd++;
            if (pause_o)  n_pa++;
            if (tone_o)   n_to++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            tick(3);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
            tick(2);
        end
        tick(2);
        ser_en = 1'b1;
        tick(4);
        ser_en = 1'b0;
        tick(14);
    endtask

    function automatic string req_of(input int e);
        case (e)
            E_DIG:   return "R3";
            E_FLASH, E_REDIAL, E_PAUSE, E_TONE: return "R5";
            E_SPK, E_MUTE: return "R6";
            E_GAIN:  return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check_levels(input string req);
        chk(req, "spk_on", int'(spk_on_o), int'(exp_spk));
        chk(req, "mic_mute", int'(mic_mute_o), int'(exp_mute));
        chk(req, "gain", int'(spk_gain_o), int'(exp_gain));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int d_dig, d_fl, d_rd, d_pa, d_to;
        int e_dig, e_fl, e_rd, e_pa, e_to;
        string rq;

        // R10: reset state
        tick(4);
        chk("R10", "pulses", int'({digit_stb_o, flash_o, redial_o, pause_o, tone_o}), 0);
        chk("R10", "toggles", int'({spk_on_o, mic_mute_o}), 0);
        chk("R10", "gain", int'(spk_gain_o), 0);
        chk("R10", "free", int'(host_free_o), 0);
        rst_n = 1'b1;
        tick(6);

        // R9: free line follows busy
        chk("R9", "free idle", int'(host_free_o), 1);
        busy = 1'b1; tick(2);
        chk("R9", "free busy", int'(host_free_o), 0);
        busy = 1'b0; tick(2);
        chk("R9", "free release", int'(host_free_o), 1);

        // Table walk: R3 R4 R5 R6 R7 R8 R11
        for (int v = 0; v < NVEC; v++) begin
            logic [4:0] code;
            int eff, val;
            code = VEC[v][15:11];
            eff  = int'(VEC[v][9:6]);
            val  = int'(VEC[v][5:0]);
            busy = VEC[v][10];
            rq   = (eff == E_NONE && code[4] == 1'b0) ? "R4" : req_of(eff);
            d_dig = n_dig; d_fl = n_fl; d_rd = n_rd; d_pa = n_pa; d_to = n_to;
            send_bits({3'b000, code}, 5);
            e_dig = (eff == E_DIG)    ? 1 : 0;
            e_fl  = (eff == E_FLASH)  ? 1 : 0;
            e_rd  = (eff == E_REDIAL) ? 1 : 0;
            e_pa  = (eff == E_PAUSE)  ? 1 : 0;
            e_to  = (eff == E_TONE)   ? 1 : 0;
            if (eff == E_SPK)  exp_spk  = ~exp_spk;
            if (eff == E_MUTE) exp_mute = ~exp_mute;
            if (eff == E_GAIN) exp_gain = 3'(val);
            chk(rq, $sformatf("vec %0d key strobes", v), n_dig - d_dig, e_dig);
            chk(rq, $sformatf("vec %0d flash", v), n_fl - d_fl, e_fl);
            chk(rq, $sformatf("vec %0d redial", v), n_rd - d_rd, e_rd);
            chk(rq, $sformatf("vec %0d pause", v), n_pa - d_pa, e_pa);
            chk(rq, $sformatf("vec %0d tone", v), n_to - d_to, e_to);
            if (eff == E_DIG)
                chk("R3", $sformatf("vec %0d key value", v), int'(last_dig), val);
            check_levels(rq);
            busy = 1'b0;
            tick(2);
        end

        // R1: activity while deselected is ignored
        ser_mode = 1'b0;
        tick(6);
        d_fl = n_fl; d_dig = n_dig;
        send_bits(8'b0001_0001, 5);
        send_bits(8'b0001_1111, 5);
        chk("R1", "flash while off", n_fl - d_fl, 0);
        chk("R1", "key while off", n_dig - d_dig, 0);
        check_levels("R1");

        // R1: register restarts clear after re-selection
        ser_mode = 1'b1;
        tick(6);
        d_dig = n_dig;
        send_bits(8'b0000_0101, 3);
        chk("R1", "short word strobes", n_dig - d_dig, 1);
        chk("R1", "short word value", int'(last_dig), 5);

        // R2: extra leading bit falls out
        d_dig = n_dig;
        send_bits(8'b0010_0010, 6);
        chk("R2", "six-bit strobes", n_dig - d_dig, 1);
        chk("R2", "six-bit value", int'(last_dig), 2);

        // R11: back-to-back commands each give a single pulse
        d_fl = n_fl; d_rd = n_rd;
        send_bits(8'b0001_0001, 5);
        send_bits(8'b0001_0010, 5);
        chk("R11", "flash count", n_fl - d_fl, 1);
        chk("R11", "redial count", n_rd - d_rd, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule